// File: doc/BRIEF.md
# Cascaded Programmable Delay Counter

This block measures out a programmable digital delay after a trigger. All of its logic runs from one fast reference clock. When a trigger is accepted, a fixed prescaler (divide by 4, then by 16) turns the reference into a slow tick, one per 64 reference cycles. A cascade of programmable stages then counts the requested number of slow ticks. The delay word holds two fields: a low field for the last stage and a high field for the middle stage. The mode select picks one of three ways to use the cascade.

- In short mode the stages are bypassed.
- In medium mode only the last stage counts.
- In long mode a first stage of 2^DIV_W slow ticks feeds the middle stage. When the middle stage runs out, slow ticks pass on to the last stage.

The end of the slow count is registered twice: first on a slow tick edge, then on the next divide-by-4 edge. Because of this, the done pulse always falls on a prescaler boundary, whatever path through the cascade the count took.

After every done pulse the block enters a reload period of RELOAD_CYC reference cycles, 66 by default. During that period the stages take the delay word and mode again. A reload period can also be requested while the block is idle, which is how a new setting reaches the stages. Reset also starts a reload period.

Top module: `cascade_delay_counter`

## Requirements
- R1: Reset makes the block busy with done low. It then runs one reload period of RELOAD_CYC cycles, after which busy drops.
- R2: A trigger sampled high while idle, with no reload request, starts a count. Busy is high from the following cycle.
- R3: The mode select uses this encoding: 2'b00 is short, 2'b01 is medium, 2'b10 is long, and 2'b11 acts as short. Delay timing is expressed as a slow-tick total T. Done is high in the cycle that follows clock edge number 64*(T+1)+4 after the edge that accepted the trigger. In short mode T is 0.
- R4: In medium mode T is bits [14:0] of the low field, which is dly_word[15:0]. Bit 15 of that field is ignored. A value of 0 gives T = 0.
- R5: In long mode T = H*2^DIV_W + L. H is the high field dly_word[31:16] and L is the low field. Either field may be 0.
- R6: Done is a single-cycle pulse and is only ever high while busy is high. Counting stops when done is reached.
- R7: The cycle after done, a reload period of RELOAD_CYC cycles begins, with busy held high throughout. The stages and the mode take the values present at the inputs during the last reload cycle.
- R8: A trigger or reload request that arrives while busy is ignored. Neither moves the pending done pulse.
- R9: Changes to the delay word or mode outside a reload period have no effect. A reload request while idle starts a reload period. If a reload request and a trigger arrive together, the reload is taken and the trigger is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Start request, sampled on the clock |
| reload_req | input | 1 | Request a reload period while idle |
| mode_sel | input | 2 | Count mode, taken during reload |
| dly_word | input | 2*STG_W | {high field, low field}, taken during reload |
| done | output | 1 | One-cycle end-of-count pulse |
| busy | output | 1 | High while counting or reloading |

## Verification
The assertions assume that trig and reload_req change only between clock edges and that reset is held for at least one clock edge. Under those assumptions, busy rising always traces back to one of the two requests. The stimulus drives every input on the falling edge. It changes the delay word and the mode only while the block is idle or counting, never during a reload that is meant to capture them. It fires spurious triggers and reload requests only while the block is busy, so that the ignore behaviour can be seen in the done timing. The bench elaborates with a small DIV_W so that long-mode delays finish in a few thousand cycles.

// File: rtl/cascade_delay_counter.sv
module cascade_delay_counter #(
  parameter int PRE_W      = 2,
  parameter int MID_W      = 4,
  parameter int STG_W      = 16,
  parameter int DIV_W      = 15,
  parameter int RELOAD_CYC = 66
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic               reload_req,
  input  logic [1:0]         mode_sel,
  input  logic [2*STG_W-1:0] dly_word,
  output logic               done,
  output logic               busy
);
  localparam int RC_W = $clog2(RELOAD_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_COUNT, S_RELOAD} st_t;

  st_t              st_q;
  logic [RC_W-1:0]  rcnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [MID_W-1:0] mid_q;
  logic [DIV_W-1:0] div_q;
  logic [STG_W-1:0] hi_q, lo_q;
  logic [1:0]       mode_q;
  logic             s1_q, s2_q;

  wire counting = (st_q == S_COUNT);
  wire is_med   = (mode_q == 2'b01);
  wire is_long  = (mode_q == 2'b10);
  wire tick4    = counting & (&pre_q);
  wire tick64   = tick4 & (&mid_q);
  wire div_puls = tick64 & is_long & (&div_q);
  wire hi_zero  = (hi_q == '0);
  wire lo_zero  = (lo_q == '0);
  wire lo_en    = tick64 & !lo_zero & (is_med | (is_long & hi_zero));
  wire sdone    = is_med ? lo_zero : is_long ? (hi_zero & lo_zero) : 1'b1;

  assign done = counting & s2_q;
  assign busy = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_RELOAD;
      rcnt_q <= '0;
      pre_q  <= '0;
      mid_q  <= '0;
      div_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      mode_q <= 2'b00;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (reload_req) begin
            st_q   <= S_RELOAD;
            rcnt_q <= '0;
          end else if (trig) begin
            st_q <= S_COUNT;
          end
        end
        S_COUNT: begin
          if (s2_q) begin
            st_q   <= S_RELOAD;
            rcnt_q <= '0;
          end else begin
            pre_q <= pre_q + 1'b1;
            if (tick4) begin
              mid_q <= mid_q + 1'b1;
              s2_q  <= s1_q;
            end
            if (tick64) begin
              s1_q <= s1_q | sdone;
              if (is_long) div_q <= div_q + 1'b1;
            end
            if (div_puls && !hi_zero) hi_q <= hi_q - 1'b1;
            if (lo_en) lo_q <= lo_q - 1'b1;
          end
        end
        default: begin
          pre_q  <= '0;
          mid_q  <= '0;
          div_q  <= '0;
          s1_q   <= 1'b0;
          s2_q   <= 1'b0;
          mode_q <= mode_sel;
          hi_q   <= dly_word[2*STG_W-1:STG_W];
          lo_q   <= (mode_sel == 2'b01) ? {1'b0, dly_word[STG_W-2:0]} : dly_word[STG_W-1:0];
          if (rcnt_q == RC_W'(RELOAD_CYC - 1)) st_q <= S_IDLE;
          else rcnt_q <= rcnt_q + 1'b1;
        end
      endcase
    end
  end
endmodule

module cascade_delay_counter_chk (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic reload_req,
  input logic done,
  input logic busy
);
  assert_done_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_reload_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> busy);
  assert_trig_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (trig || reload_req)) |=> busy);
  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig || reload_req));
endmodule

bind cascade_delay_counter cascade_delay_counter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .trig(trig), .reload_req(reload_req),
  .done(done), .busy(busy)
);

// File: tb/cascade_delay_counter_tb_top.sv
module cascade_delay_counter_tb_top;
  localparam int DIV_W = 3;
  localparam int RLD   = 66;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        reload_req = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic [31:0] dly_word = '0;
  logic        done, busy;

  always #2 clk = ~clk;

  cascade_delay_counter #(.DIV_W(DIV_W), .RELOAD_CYC(RLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .reload_req(reload_req),
    .mode_sel(mode_sel), .dly_word(dly_word), .done(done), .busy(busy)
  );

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  int mst = 2;
  int mcnt = 0;
  int mtgt = 0;
  int mmode = 0;
  int mhi = 0;
  int mlo = 0;

  function automatic int slow_total();
    if (mmode == 1) return mlo % 32768;
    if (mmode == 2) return mhi * (1 << DIV_W) + mlo;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mst = 2; mcnt = 0;
    end else begin
      case (mst)
        0: if (reload_req) begin mst = 2; mcnt = 0; end
           else if (trig) begin mst = 1; mcnt = 0; mtgt = 64 * (slow_total() + 1) + 4; end
        1: if (mcnt == mtgt) begin mst = 2; mcnt = 0; end
           else mcnt = mcnt + 1;
        default: begin
          mmode = int'(mode_sel); mhi = int'(dly_word[31:16]); mlo = int'(dly_word[15:0]);
          mcnt = mcnt + 1;
          if (mcnt == RLD) mst = 0;
        end
      endcase
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, done, (mst == 1 && mcnt == mtgt), "done");
      check(tag, busy, (mst != 0), "busy");
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (mst != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_trig();
    trig = 1'b1; @(negedge clk); trig = 1'b0;
  endtask

  task automatic do_reload(input logic [1:0] m, input logic [31:0] w);
    mode_sel = m; dly_word = w;
    reload_req = 1'b1; @(negedge clk); reload_req = 1'b0;
    wait_idle();
  endtask

  task automatic run_delay(input string req);
    tag = req;
    pulse_trig();
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", done, 1'b0, "reset done");
    check("R1", busy, 1'b1, "reset busy");
    rst_n = 1'b1;
    tag = "R1";
    wait_idle();

    tag = "R3"; do_reload(2'b00, 32'h0);
    run_delay("R3");
    tag = "R3"; do_reload(2'b11, 32'h0003_0007);
    run_delay("R3");

    tag = "R4"; do_reload(2'b01, 32'h0000_8005);
    tag = "R8"; pulse_trig();
    repeat (100) @(negedge clk);
    pulse_trig();
    reload_req = 1'b1; @(negedge clk); reload_req = 1'b0;
    tag = "R9"; dly_word = 32'h0000_0020; mode_sel = 2'b10;
    wait_idle();
    tag = "R9"; run_delay("R9");

    tag = "R4"; do_reload(2'b01, 32'h0000_0000);
    run_delay("R4");
    tag = "R4"; do_reload(2'b01, 32'h0000_0003);
    run_delay("R4");

    tag = "R5"; do_reload(2'b10, 32'h0002_0003);
    run_delay("R5");
    tag = "R5"; do_reload(2'b10, 32'h0000_0004);
    run_delay("R5");
    tag = "R5"; do_reload(2'b10, 32'h0001_0000);
    run_delay("R5");

    tag = "R9"; mode_sel = 2'b00; dly_word = 32'h0;
    trig = 1'b1; reload_req = 1'b1; @(negedge clk);
    trig = 1'b0; reload_req = 1'b0;
    wait_idle();
    run_delay("R6");
    tag = "R7"; repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule